// File: doc/BRIEF.md
# Single-Cycle Register-to-Register ALU Step Engine

This block runs one register-to-register arithmetic instruction per clock. A 16-bit instruction word arrives on an input port. The block splits it into four nibbles, reads two operands out of an internal file of 64-bit registers, and forms the result in an ALU. On the next rising edge it commits the result to the destination register, the zero/sign/overflow flags and the program counter, all together.

The register file has two combinational read ports, and both read values are visible at the block's outputs. A surrounding fetch stage, or a testbench, can therefore look at any register pair by presenting an instruction that names it. Any instruction outside the ALU class leaves the architectural state untouched and raises a halt indication. The same holds for an ALU-class word with an undefined function nibble. The block has no instruction memory, no data memory, no branches and no immediates.

Top module: `alu_step_core`

## Requirements
- R1: Instruction bits [15:12] are the class code, [11:8] the function code, [7:4] operand register A and [3:0] register B. Class code 6 is the ALU class.
- R2: With class 6, function 0 computes B+A, 1 computes B−A, 2 computes B AND A and 3 computes B XOR A. The result is written into register B on the next rising edge.
- R3: `opa_o` and `opb_o` show, combinationally, the registers named by the A and B fields. ID 15 names no register and always reads 0.
- R4: A legal ALU instruction whose B field is 15 writes no register, but its flags and PC update still happen.
- R5: Every legal ALU instruction advances `pc_o` by 2 on the rising edge.
- R6: For any class code other than 6, `halt_o` is 1, and the PC, the flags and all registers keep their values over the edge.
- R7: With class 6 and a function code above 3, `halt_o` is 1 and no register, flag or PC changes.
- R8: `flags_o[2]` is zero (set when the 64-bit result is 0) and `flags_o[1]` is sign (bit 63 of the result). Both are written on each legal ALU instruction.
- R9: `flags_o[0]` is signed overflow for add and subtract, and is always 0 after AND and XOR.
- R10: A synchronous active-high reset clears the PC and the flags and loads each register with its own ID (register i holds i).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instr_i | input | 16 | Instruction word under execution |
| opa_o | output | 64 | Value of the register named by field A |
| opb_o | output | 64 | Value of the register named by field B |
| pc_o | output | 64 | Program counter |
| flags_o | output | 3 | {zero, sign, overflow} |
| halt_o | output | 1 | Current instruction is not a legal ALU operation |

## Verification
The assertions assume that `instr_i` is stable and fully known around each rising edge. They also assume that reset is held across at least one edge before execution starts, so the PC and flag history they compare against is defined. The bench changes the instruction word only shortly after a rising edge, with one word per cycle. It holds reset over two edges at the start and pulses it for a single edge once in mid-run. Between those points it mixes directed sequences with pseudo-random words, of which about half carry class code 6.

// File: rtl/alu_step_core.sv
module alu_step_core #(
  parameter int XLEN     = 64,
  parameter int IDW      = 4,
  parameter int NREG     = 15,
  parameter int PC_STEP  = 2,
  parameter int ALU_CODE = 6,
  parameter int FUN_LAST = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [15:0]     instr_i,
  output logic [XLEN-1:0] opa_o,
  output logic [XLEN-1:0] opb_o,
  output logic [XLEN-1:0] pc_o,
  output logic [2:0]      flags_o,
  output logic            halt_o
);
  localparam int MSB = XLEN - 1;
  localparam logic [IDW-1:0] NULL_ID = IDW'(NREG);

  logic [3:0]     icode, ifun;
  logic [IDW-1:0] ra, rb;
  assign icode = instr_i[15:12];
  assign ifun  = instr_i[11:8];
  assign ra    = instr_i[7:4];
  assign rb    = instr_i[3:0];

  logic legal, wr_en;
  assign legal = (icode == 4'(ALU_CODE)) && (ifun <= 4'(FUN_LAST));
  assign wr_en = legal && (rb != NULL_ID);
  assign halt_o = !legal;

  logic [XLEN-1:0] rf [NREG];
  logic [XLEN-1:0] result;
  logic            ovf;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [IDW-1:0] MY_ID = IDW'(i);
    logic [XLEN-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= XLEN'(i);
      else if (wr_en && rb == MY_ID) q <= result;
    end
    assign rf[i] = q;
  end

  assign opa_o = (ra < NULL_ID) ? rf[ra] : '0;
  assign opb_o = (rb < NULL_ID) ? rf[rb] : '0;

  always_comb begin
    result = '0;
    ovf    = 1'b0;
    case (ifun)
      4'd0: begin
        result = opb_o + opa_o;
        ovf    = (opa_o[MSB] == opb_o[MSB]) && (result[MSB] != opb_o[MSB]);
      end
      4'd1: begin
        result = opb_o - opa_o;
        ovf    = (opa_o[MSB] != opb_o[MSB]) && (result[MSB] != opb_o[MSB]);
      end
      4'd2: result = opb_o & opa_o;
      4'd3: result = opb_o ^ opa_o;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_o    <= '0;
      flags_o <= '0;
    end else if (legal) begin
      pc_o    <= pc_o + XLEN'(PC_STEP);
      flags_o <= {result == '0, result[MSB], ovf};
    end
  end
endmodule

module alu_step_core_chk #(
  parameter int XLEN     = 64,
  parameter int PC_STEP  = 2,
  parameter int ALU_CODE = 6
) (
  input logic            clk,
  input logic            rst,
  input logic [15:0]     instr,
  input logic [XLEN-1:0] pc,
  input logic [2:0]      flags,
  input logic            halt,
  input logic [XLEN-1:0] opa
);
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (pc == '0 && flags == 3'b000)); // R10
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst) !halt |=> pc == $past(pc) + XLEN'(PC_STEP)); // R5
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst) halt |=> $stable(pc)); // R6
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst) halt |=> $stable(flags)); // R7
  AST_HALT_CLASS: assert property (@(posedge clk) disable iff (rst) instr[15:12] != 4'(ALU_CODE) |-> halt); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) (!halt && instr[11:8] >= 4'd2) |=> !flags[0]); // R9
  AST_NULL_READ: assert property (@(posedge clk) disable iff (rst) instr[7:4] == 4'hF |-> opa == '0); // R3
  AST_SELF_XOR_ZERO: assert property (@(posedge clk) disable iff (rst) (!halt && instr[11:8] == 4'd3 && instr[7:4] == instr[3:0]) |=> flags[2]); // R8
endmodule

bind alu_step_core alu_step_core_chk #(.XLEN(XLEN), .PC_STEP(PC_STEP), .ALU_CODE(ALU_CODE)) u_chk (
  .clk(clk), .rst(rst), .instr(instr_i), .pc(pc_o),
  .flags(flags_o), .halt(halt_o), .opa(opa_o)
);

// File: tb/sim_alu_step_core.sv
`timescale 1ns/1ps
module sim_alu_step_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instr = 16'h1000;
  logic [63:0] opa_o, opb_o, pc_o;
  logic [2:0]  flags_o;
  logic        halt_o;

  always #10 clk = ~clk;

  alu_step_core u0 (
    .clk(clk), .rst(rst), .instr_i(instr), .opa_o(opa_o), .opb_o(opb_o),
    .pc_o(pc_o), .flags_o(flags_o), .halt_o(halt_o)
  );

  typedef struct {
    logic [63:0] pc, opa, opb;
    logic [2:0]  fl;
    logic        halt;
    string       tag;
  } exp_t;

  exp_t        q[$];
  logic [63:0] m_reg [15];
  logic [63:0] m_pc;
  logic [2:0]  m_fl;
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  function automatic logic [63:0] rd(input logic [3:0] id);
    return (id == 4'hF) ? 64'd0 : m_reg[id];
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 15; i++) m_reg[i] = 64'(i);
    m_pc = '0;
    m_fl = '0;
  endtask

  // R1 field layout, R2 functions, R8/R9 flags computed from a 65-bit view
  task automatic model_exec(input logic [15:0] w);
    logic [63:0] a, b, r;
    logic [64:0] wide;
    logic        o;
    a = rd(w[7:4]);
    b = rd(w[3:0]);
    if (w[15:12] == 4'd6 && w[11:8] <= 4'd3) begin
      o = 1'b0;
      case (w[11:8])
        4'd0: begin wide = {b[63], b} + {a[63], a}; r = wide[63:0]; o = wide[64] ^ wide[63]; end
        4'd1: begin wide = {b[63], b} - {a[63], a}; r = wide[63:0]; o = wide[64] ^ wide[63]; end
        4'd2: r = b & a;
        default: r = b ^ a;
      endcase
      m_fl = {r == 64'd0, r[63], o};
      if (w[3:0] != 4'hF) m_reg[w[3:0]] = r;
      m_pc = m_pc + 64'd2;
    end
  endtask

  task automatic step(input logic [15:0] w, input string tag);
    exp_t e;
    @(posedge clk);
    #2;
    instr = w;
    e.pc   = m_pc;
    e.fl   = m_fl;
    e.opa  = rd(w[7:4]);
    e.opb  = rd(w[3:0]);
    e.halt = !(w[15:12] == 4'd6 && w[11:8] <= 4'd3);
    e.tag  = tag;
    q.push_back(e);
    model_exec(w);
  endtask

  task automatic peek(input logic [3:0] a, input logic [3:0] b, input string tag);
    step({8'h10, a, b}, tag);
  endtask

  task automatic pulse_reset();
    @(posedge clk);
    #2;
    rst = 1'b1;
    instr = 16'h1000;
    @(posedge clk);
    #2;
    rst = 1'b0;
    model_reset();
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        bit   bad;
        e = q.pop_front();
        bad = 0;
        n_vec++;
        if (pc_o !== e.pc) begin bad = 1; $display("FAIL %s pc got %h exp %h", e.tag, pc_o, e.pc); end
        if (flags_o !== e.fl) begin bad = 1; $display("FAIL %s flags got %b exp %b", e.tag, flags_o, e.fl); end
        if (opa_o !== e.opa) begin bad = 1; $display("FAIL %s opa got %h exp %h", e.tag, opa_o, e.opa); end
        if (opb_o !== e.opb) begin bad = 1; $display("FAIL %s opb got %h exp %h", e.tag, opb_o, e.opb); end
        if (halt_o !== e.halt) begin bad = 1; $display("FAIL %s halt got %b exp %b", e.tag, halt_o, e.halt); end
        if (bad) n_bad++;
      end
    end
  end

  initial begin
    #4_000_000;
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired with %0d items pending", q.size());
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (2) @(posedge clk);
    #2;
    rst = 1'b0;

    peek(4'd0, 4'd1, "R10 reset ids");
    peek(4'd13, 4'd14, "R10 reset ids");
    peek(4'd15, 4'd15, "R3 null id reads zero");
    step(16'h6012, "R2 add");
    peek(4'd2, 4'd1, "R2 add result");
    step(16'h6153, "R2 sub");
    peek(4'd3, 4'd5, "R2 sub negative");
    step(16'h6225, "R2 and");
    step(16'h6344, "R8 xor self zero");
    peek(4'd4, 4'd5, "R8 zero flag");
    step(16'h6377, "R9 clear r7");
    step(16'h6017, "R9 seed r7");
    step(16'h6388, "R9 clear r8");
    step(16'h6018, "R9 seed r8");
    for (int k = 0; k < 63; k++) step(16'h6077, "R9 add doubling");
    peek(4'd7, 4'd8, "R9 add overflow");
    step(16'h6187, "R9 sub overflow");
    peek(4'd7, 4'd8, "R9 sub result");
    step(16'h6278, "R9 and clears overflow");
    step(16'h601F, "R4 write to null id");
    peek(4'd1, 4'd15, "R4 null untouched");
    step(16'h7012, "R6 other class");
    step(16'h1234, "R6 other class");
    step(16'h0000, "R6 other class");
    step(16'h6412, "R7 illegal function");
    step(16'h6F21, "R7 illegal function");
    peek(4'd2, 4'd1, "R7 registers kept");
    pulse_reset();
    peek(4'd2, 4'd7, "R10 mid-run reset");
    step(16'h6112, "R5 pc after reset");
    for (int k = 0; k < 80; k++) begin
      logic [15:0] w;
      w = 16'($urandom);
      if (k % 2 == 0) w[15:12] = 4'd6;
      step(w, "R1 random word");
    end
    peek(4'd0, 4'd1, "R1 final");
    peek(4'd2, 4'd3, "R1 final");
    wait (q.size() == 0);
    @(negedge clk);
    #1;
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule